// File: doc/BRIEF.md
# Keyed Countdown Watchdog Timer

This block is a memory-mapped watchdog for a system that must be reset when software stops servicing it. A 16-bit counter counts down in steps produced by a programmable prescaler, which divides a slow 32768 Hz tick enable supplied from outside. When the counter reaches zero while the block is enabled, it raises a reset request for a single clock cycle and latches a sticky expired flag that software can read and clear.

Software talks to the block over a plain 32-bit register bus with read and write strobes, a byte address, write data and read data. Every write must carry a fixed 16-bit key in its upper half, or it is dropped. Divisor and reload values written by software land in shadow registers. They reach the running prescaler and counter only when software flips the matching two-bit group of the refresh register between its two legal codes. A keepalive is therefore a read of the refresh register, an inversion of its low six bits, and a keyed write back.

Reads are combinational: read data is valid in the same cycle as the read strobe and is zero when the strobe is low.

Top module: `keyed_wdt`

## Requirements
- R1: After reset the config register reads 0x00000F00 (divisor 16), the load register reads 0x0000FFFF, the refresh register reads 0x00000015, the start register reads 0, and the reset request output is low.
- R2: A write changes state only when write data bits 31:16 equal 0x1234. A write with any other key leaves every register, the enable and the running count untouched.
- R3: Registers sit at byte offsets 0x04 (config: divisor minus one in bits 15:8), 0x08 (load: bits 15:0), 0x18 (refresh: bits 5:0) and 0x1C (start: bit 0 enable, bit 1 expired). Unused bits read as 0. A write to any other offset changes nothing, and a read of any other offset returns 0.
- R4: The refresh register holds three two-bit groups: bits 5:4 for configuration, bits 3:2 for the counter and bits 1:0 for the interrupt value. A group takes a newly written code only when that code is 1 and the stored code is 2, or the reverse. Writing the same code, 0 or 3 leaves the group as it was.
- R5: Writes to config and load do not alter a running count. The new values take effect only on an accepted flip of the matching refresh group.
- R6: An accepted flip of the counter group loads the counter from the load register and restarts the prescaler. With the tick held high, divisor D and load L, the reset request rises exactly L*D clock edges after counting begins.
- R7: While start bit 0 is clear, the counter and prescaler hold, and no reset request is raised.
- R8: When an enabled count steps from 1 to 0, the reset request is high for exactly one cycle and start bit 1 is set. The counter then stays at 0 and raises no further request until it is reloaded.
- R9: A keyed write to the start register with bit 1 set clears the expired flag. Bit 0 of the same write sets the enable.
- R10: An accepted flip of the configuration group copies the shadow divisor into the prescaler and restarts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle enable at the 32768 Hz time base |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Byte offset of the register |
| bus_wdata | input | 32 | Write data: key in 31:16, value in 15:0 |
| bus_rdata | output | 32 | Read data, combinational |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
The assertions assume that read and write strobes are never raised in the same cycle, and that the address and write data are steady while a strobe is high. The bench keeps to these assumptions because a single task drives each access, one at a time. The expiry timing is checked with the tick enable held high. Each divisor and load combination therefore gives an exact edge count, which the bench compares against a free-running cycle counter.

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
  parameter int          AW        = 8,
  parameter logic [15:0] KEY       = 16'h1234,
  parameter logic [7:0]  RST_DIVM1 = 8'd15,
  parameter logic [15:0] RST_LOAD  = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          rst_req
);

  localparam logic [AW-1:0] OFF_CFG   = AW'('h04);
  localparam logic [AW-1:0] OFF_LOAD  = AW'('h08);
  localparam logic [AW-1:0] OFF_REF   = AW'('h18);
  localparam logic [AW-1:0] OFF_START = AW'('h1C);
  localparam int            NGRP      = 3;
  localparam logic [5:0]    RST_CODES = 6'h15;

  logic [7:0]  sh_div, act_div, pcnt;
  logic [15:0] sh_load, cnt;
  logic [5:0]  codes;
  logic        en, expired;
  logic [NGRP-1:0] flip;

  wire wr_ok  = bus_wr && (bus_wdata[31:16] == KEY);
  wire wr_cfg = wr_ok && (bus_addr == OFF_CFG);
  wire wr_ld  = wr_ok && (bus_addr == OFF_LOAD);
  wire wr_ref = wr_ok && (bus_addr == OFF_REF);
  wire wr_st  = wr_ok && (bus_addr == OFF_START);

  for (genvar g = 0; g < NGRP; g++) begin : g_flip
    wire [1:0] oldc = codes[2*g +: 2];
    wire [1:0] newc = bus_wdata[2*g +: 2];
    assign flip[g] = wr_ref && ((oldc == 2'd1 && newc == 2'd2) ||
                                (oldc == 2'd2 && newc == 2'd1));
  end

  wire restart = flip[1] | flip[2];
  wire step    = en && tick_en && !restart && (pcnt == act_div);
  wire fire    = step && (cnt == 16'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_div  <= RST_DIVM1;
      sh_load <= RST_LOAD;
      en      <= 1'b0;
    end else begin
      if (wr_cfg) sh_div  <= bus_wdata[15:8];
      if (wr_ld)  sh_load <= bus_wdata[15:0];
      if (wr_st)  en      <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) codes <= RST_CODES;
    else
      for (int g = 0; g < NGRP; g++)
        if (flip[g]) codes[2*g +: 2] <= bus_wdata[2*g +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_div <= RST_DIVM1;
      pcnt    <= 8'd0;
    end else begin
      if (flip[2]) act_div <= sh_div;
      if (restart)                pcnt <= 8'd0;
      else if (en && tick_en)     pcnt <= (pcnt == act_div) ? 8'd0 : pcnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= RST_LOAD;
    else if (flip[1])                cnt <= sh_load;
    else if (step && cnt != 16'd0)   cnt <= cnt - 16'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      expired <= 1'b0;
    end else begin
      rst_req <= fire;
      if (fire)                       expired <= 1'b1;
      else if (wr_st && bus_wdata[1]) expired <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    if (bus_rd)
      case (bus_addr)
        OFF_CFG:   bus_rdata = {16'd0, sh_div, 8'd0};
        OFF_LOAD:  bus_rdata = {16'd0, sh_load};
        OFF_REF:   bus_rdata = {26'd0, codes};
        OFF_START: bus_rdata = {30'd0, expired, en};
        default:   bus_rdata = 32'd0;
      endcase
  end

  AST_RSTREQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req); // R8
  AST_RSTREQ_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> expired); // R8
  AST_BADKEY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_wdata[31:16] != KEY) |=>
      ($stable(sh_div) && $stable(sh_load) && $stable(en) && $stable(codes))); // R2
  AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !restart) |=> ($stable(cnt) && $stable(pcnt) && !rst_req)); // R7
  AST_CODES_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ((codes[1:0] == 2'd1 || codes[1:0] == 2'd2) &&
     (codes[3:2] == 2'd1 || codes[3:2] == 2'd2) &&
     (codes[5:4] == 2'd1 || codes[5:4] == 2'd2))); // R4
  AST_COUNT_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !flip[1] |=> (cnt == $past(cnt) || cnt == $past(cnt) - 16'd1)); // R6

endmodule

// File: tb/keyed_wdt_bench.sv
module keyed_wdt_bench;
  localparam logic [15:0] K = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0, tick_en = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = 8'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        rst_req;

  int total = 0, bad = 0, cyc = 0, c0 = 0, n = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  keyed_wdt u_keyed_wdt (.clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (bus_rd) begin
    if (exp_q.size() == 0) check("scoreboard underflow", 32'd1, 32'd0);
    else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] key, input logic [15:0] v);
    @(posedge clk); #2;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = {key, v};
    @(posedge clk); #2;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #2;
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #2;
    bus_rd = 1'b0;
  endtask

  task automatic wait_pulse(input int from, output int edges);
    edges = -1;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (rst_req) begin edges = cyc - from; break; end
    end
  endtask

  task automatic quiet(input int cycles, input string tag);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (rst_req) seen++;
    end
    check(tag, seen, 0);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    check("R1 rst_req low", {31'd0, rst_req}, 0);
    rd(8'h04, 32'h0F00, "R1 config reset");
    rd(8'h08, 32'hFFFF, "R1 load reset");
    rd(8'h18, 32'h15,   "R1 refresh reset");
    rd(8'h1C, 32'h0,    "R1 start reset");

    // R6 R10: divisor 2, load 3 -> 6 edges
    wr(8'h04, K, 16'h0100);
    wr(8'h08, K, 16'd3);
    wr(8'h18, K, 16'h2A);
    rd(8'h18, 32'h2A, "R4 all groups flipped");
    wr(8'h1C, K, 16'h1); c0 = cyc;
    wait_pulse(c0, n);
    check("R6 R10 expiry edges D=2 L=3", n, 6);
    rd(8'h1C, 32'h3, "R8 expired flag set");
    quiet(30, "R8 single pulse then hold at zero");
    wr(8'h1C, K, 16'h3);
    rd(8'h1C, 32'h1, "R9 expired cleared, enable kept");
    wr(8'h1C, K, 16'h0);

    // R7: stopped count does not expire
    wr(8'h04, K, 16'h0000);
    wr(8'h08, K, 16'd1);
    wr(8'h18, K, 16'h15);
    quiet(40, "R7 no expiry while stopped");
    wr(8'h1C, K, 16'h1); c0 = cyc;
    wait_pulse(c0, n);
    check("R7 resumes, expiry D=1 L=1", n, 1);
    wr(8'h1C, K, 16'h2);
    rd(8'h1C, 32'h0, "R9 clear with enable off");

    // R5 + R4: shadow load and unchanged code do not reload
    wr(8'h08, K, 16'd20);
    wr(8'h18, K, 16'h2A);
    wr(8'h08, K, 16'd50);
    wr(8'h1C, K, 16'h1); c0 = cyc;
    repeat (5) @(posedge clk);
    wr(8'h18, K, 16'h2A);
    wait_pulse(c0, n);
    check("R5 R4 count unaffected by shadow and same code", n, 20);
    wr(8'h1C, K, 16'h2);

    // R6: counter group flip mid-run reloads from shadow
    wr(8'h1C, K, 16'h1);
    repeat (5) @(posedge clk);
    wr(8'h18, K, 16'h26); c0 = cyc;
    wait_pulse(c0, n);
    check("R6 mid-run reload from load 50", n, 50);
    wr(8'h1C, K, 16'h2);
    rd(8'h18, 32'h26, "R4 only counter group flipped");

    // R4 illegal codes
    wr(8'h18, K, 16'h3F);
    rd(8'h18, 32'h26, "R4 code 3 ignored");
    wr(8'h18, K, 16'h00);
    rd(8'h18, 32'h26, "R4 code 0 ignored");

    // R2 key
    wr(8'h08, 16'hABCD, 16'h7);
    rd(8'h08, 32'd50, "R2 bad key load ignored");
    wr(8'h1C, 16'h1235, 16'h1);
    rd(8'h1C, 32'h0, "R2 bad key start ignored");
    wr(8'h18, 16'h0000, 16'h15);
    rd(8'h18, 32'h26, "R2 bad key refresh ignored");

    // R3 map
    wr(8'h0C, K, 16'h1);
    wr(8'h05, K, 16'hFFFF);
    rd(8'h04, 32'h0000, "R3 unmapped write config intact");
    rd(8'h08, 32'd50,   "R3 unmapped write load intact");
    rd(8'h1C, 32'h0,    "R3 unmapped write start intact");
    rd(8'h0C, 32'h0,    "R3 unmapped read zero");
    wr(8'h04, K, 16'hFFFF);
    rd(8'h04, 32'hFF00, "R3 config field bits 15:8 only");

    done = 1'b1;
    repeat (4) @(posedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule